// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block collects interrupt requests from a parameterized number of input lines (64 by default) on behalf of a small processor. For every line it keeps four pieces of state: an enable bit, a pending bit, an active bit and a priority. Software reaches this state through a word-addressed register bus with byte strobes. Enable and pending each have a pair of banks, one to set bits and one to clear them. Writing a 1 changes the matching bit and writing a 0 leaves it alone, so software never has to read, modify and write back a word.

Each cycle the block picks the most urgent request among lines that are enabled, pending and not active. It offers that request to the core as a number and a priority. The core's acknowledge pulse moves the chosen line from pending to active. A later completion pulse, which carries a line number, clears that line's active bit. A line that is still high once its active bit has cleared becomes pending again.

Top module: `vic_core`

## Requirements
- R1: After reset every enable, pending, active and priority bit is zero, every readable word returns 0, and `irq_req` is low.
- R2: Line n maps to word n/32, bit n%32 of each bit bank. The set-enable bank sits at word offset 0 and the clear-enable bank at word offset 32. A 1 written to a bit sets or clears that enable bit, and a 0 bit leaves it unchanged.
- R3: A read of either enable bank returns the current enable bits.
- R4: The set-pending bank (word offset 64) and the clear-pending bank (word offset 96) act on the pending bits the same way. A read of either one returns the current pending bits.
- R5: In a bit-bank write, byte lane k carries bits 8k to 8k+7. Bits in a lane whose `bus_strb` bit is 0 are not changed.
- R6: The active bank at word offset 128 returns the active bits. Writes to it are ignored.
- R7: Line n's priority lies at word 160 + n/4, bits (n%4)*8 to (n%4)*8+7. A write updates only the fields whose strobe lane is set. Only the top PRIO_BITS bits (default 2) are stored, and the lower bits read as 0.
- R8: The arbiter considers only lines that are enabled, pending and not active. It picks the one with the numerically lowest priority, and a tie goes to the lowest line number. It drives that line's number on `irq_id` and its priority on `irq_prio`.
- R9: `irq_req` is high only when a candidate exists and `irq_prio` is strictly lower than `run_prio`.
- R10: An `ack` pulse while `irq_req` is high clears the pending bit and sets the active bit of `irq_id` at the next edge. An `ack` pulse while `irq_req` is low changes nothing.
- R11: A `done` pulse clears the active bit of line `done_id` at the next edge.
- R12: A hardware line sets its pending bit on a rising edge, or on any cycle in which it is high and its line is not active. In a single cycle a software set-pending write wins over every clear, and both an acknowledge and a software clear win over a hardware request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word address (bank in bits 7:5, word in bits 4:0) |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte lane enables for writes |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | N_IRQ | Interrupt request lines |
| run_prio | input | 8 | Priority the core is currently running at |
| irq_req | output | 1 | Request to the core |
| irq_id | output | IDW | Number of the selected line |
| irq_prio | output | 8 | Priority of the selected line |
| ack | input | 1 | Core accepts the offered interrupt |
| done | input | 1 | Core finished servicing `done_id` |
| done_id | input | IDW | Line whose service is complete |

## Verification
The acknowledge property assumes that no software set-pending write to the acknowledged line lands in the same cycle as `ack`, since the set would legitimately win. The completion property leaves out the cycle in which `ack` targets the same line. The stimulus honours both conditions by never overlapping a bus write with `ack` or `done`. It also issues `done` only for lines it knows are active. Every input changes on the falling edge, so all properties see stable values at the rising edge.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int N_IRQ     = 64,
  parameter int PRIO_BITS = 2,
  parameter int IDW       = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic [3:0]       bus_strb,
  output logic [31:0]      bus_rdata,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [7:0]       run_prio,
  output logic             irq_req,
  output logic [IDW-1:0]   irq_id,
  output logic [7:0]       irq_prio,
  input  logic             ack,
  input  logic             done,
  input  logic [IDW-1:0]   done_id
);
  localparam logic [2:0] B_SETEN = 3'd0, B_CLREN = 3'd1, B_SETPD = 3'd2,
                         B_CLRPD = 3'd3, B_ACT = 3'd4, B_PRIO = 3'd5;
  localparam int LOWB = 8 - PRIO_BITS;
  localparam logic [7:0]  LOWB8   = 8'((1 << LOWB) - 1);
  localparam logic [31:0] LOWMASK = {4{LOWB8}};

  logic [N_IRQ-1:0] en, pend, act, irq_q;
  logic [PRIO_BITS-1:0] prio [N_IRQ];

  logic [2:0] bank;
  logic [4:0] widx;
  assign bank = bus_addr[7:5];
  assign widx = bus_addr[4:0];

  logic [N_IRQ-1:0] wbits;
  always_comb begin
    for (int i = 0; i < N_IRQ; i++)
      wbits[i] = (widx == 5'(i / 32)) && bus_wdata[i % 32] && bus_strb[(i % 32) / 8];
  end

  logic [N_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, ack_mask, done_mask, hw_set;
  logic ack_go;
  assign en_set    = {N_IRQ{bus_wr && bank == B_SETEN}} & wbits;
  assign en_clr    = {N_IRQ{bus_wr && bank == B_CLREN}} & wbits;
  assign pd_set    = {N_IRQ{bus_wr && bank == B_SETPD}} & wbits;
  assign pd_clr    = {N_IRQ{bus_wr && bank == B_CLRPD}} & wbits;
  assign ack_go    = ack && irq_req;
  assign ack_mask  = ack_go ? (N_IRQ'(1) << irq_id) : '0;
  assign done_mask = done ? (N_IRQ'(1) << done_id) : '0;
  assign hw_set    = irq_in & (~irq_q | ~act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= '0;
      pend  <= '0;
      act   <= '0;
      irq_q <= '0;
      for (int i = 0; i < N_IRQ; i++) prio[i] <= '0;
    end else begin
      en    <= (en & ~en_clr) | en_set;
      pend  <= ((pend | hw_set) & ~ack_mask & ~pd_clr) | pd_set;
      act   <= (act & ~done_mask) | ack_mask;
      irq_q <= irq_in;
      for (int i = 0; i < N_IRQ; i++)
        if (bus_wr && bank == B_PRIO && widx == 5'(i / 4) && bus_strb[i % 4])
          prio[i] <= bus_wdata[(i % 4) * 8 + 7 -: PRIO_BITS];
    end
  end

  logic                 found;
  logic [PRIO_BITS-1:0] best;
  logic [IDW-1:0]       bid;
  always_comb begin
    found = 1'b0;
    best  = '1;
    bid   = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (en[i] && pend[i] && !act[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        best  = prio[i];
        bid   = IDW'(i);
      end
  end

  assign irq_id   = bid;
  assign irq_prio = 8'(best) << LOWB;
  assign irq_req  = found && (irq_prio < run_prio);

  logic [N_IRQ-1:0] rvec;
  always_comb begin
    case (bank)
      B_SETEN, B_CLREN: rvec = en;
      B_SETPD, B_CLRPD: rvec = pend;
      B_ACT:            rvec = act;
      default:          rvec = '0;
    endcase
    bus_rdata = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (bank != B_PRIO && widx == 5'(i / 32)) bus_rdata[i % 32] = rvec[i];
      if (bank == B_PRIO && widx == 5'(i / 4))
        bus_rdata[(i % 4) * 8 +: 8] = 8'(prio[i]) << LOWB;
    end
  end

  // R2
  set_bank_never_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bank == B_SETEN) |=> ((en & $past(en)) == $past(en)));
  // R2
  clr_bank_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bank == B_CLREN) |=> ((en | $past(en)) == $past(en)));
  // R6
  active_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bank == B_ACT && !ack_go && !done) |=> $stable(act));
  // R7
  prio_low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank == B_PRIO) |-> ((bus_rdata & LOWMASK) == '0));
  // R8
  req_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en[irq_id] && pend[irq_id] && !act[irq_id]));
  // R10
  ack_moves_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_go && !bus_wr) |=> (act[$past(irq_id)] && !pend[$past(irq_id)]));
  // R11
  done_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(ack_go && irq_id == done_id)) |=> !act[$past(done_id)]);
endmodule

// File: tb/vic_core_bench.sv
module vic_core_bench;
  localparam int N = 64;
  localparam int IDW = 6;

  logic clk = 0, rst_n = 0, bus_wr = 0, ack = 0, done = 0;
  logic [7:0] bus_addr = 0, run_prio = 8'hFF;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0] bus_strb = 0;
  logic [N-1:0] irq_in = 0;
  logic irq_req;
  logic [IDW-1:0] irq_id, done_id = 0;
  logic [7:0] irq_prio;

  vic_core #(.N_IRQ(N), .PRIO_BITS(2)) u_vic_core (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .run_prio(run_prio), .irq_req(irq_req), .irq_id(irq_id),
    .irq_prio(irq_prio), .ack(ack), .done(done), .done_id(done_id));

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic [N-1:0] en_m = 0, pd_m = 0, ac_m = 0;
  logic [7:0] pm [N];

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_strb = s; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic pulse_done(input int id);
    @(negedge clk); done = 1; done_id = IDW'(id);
    @(negedge clk); done = 0;
  endtask

  function automatic int arb(output logic [7:0] bp);
    int b = -1;
    bp = 8'hFF;
    for (int i = 0; i < N; i++)
      if (en_m[i] && pd_m[i] && !ac_m[i] && (b < 0 || pm[i] < bp)) begin
        b = i; bp = pm[i];
      end
    return b;
  endfunction

  task automatic set_vec(input logic [7:0] setb, input logic [7:0] clrb, input logic [N-1:0] v);
    wr(clrb, 32'hFFFF_FFFF, 4'hF);
    wr(clrb + 1, 32'hFFFF_FFFF, 4'hF);
    wr(setb, v[31:0], 4'hF);
    wr(setb + 1, v[63:32], 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired got hung exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    logic [7:0] bp;
    int id;
    for (int i = 0; i < N; i++) pm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state across the whole address space
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d);
      chk("R1 reset read", d, 0);
    end
    chk("R1 no request", 32'(irq_req), 0);

    // R2 R3 enable set sweep, one line at a time
    for (int i = 0; i < N; i++) begin
      wr(8'(i / 32), 32'h1 << (i % 32), 4'hF);
      en_m[i] = 1;
      rd(8'(i / 32), d);
      chk("R2 set-enable", d, en_m[(i / 32) * 32 +: 32]);
      if (i % 8 == 7) begin
        rd(8'(32 + i / 32), d);
        chk("R3 clear bank reads enables", d, en_m[(i / 32) * 32 +: 32]);
      end
    end
    for (int i = 0; i < N; i += 2) begin
      wr(8'(32 + i / 32), 32'h1 << (i % 32), 4'hF);
      en_m[i] = 0;
      rd(8'(i / 32), d);
      chk("R2 clear-enable", d, en_m[(i / 32) * 32 +: 32]);
    end
    wr(8'd32, 0, 4'hF);
    wr(8'd1, 0, 4'hF);
    rd(8'd0, d); chk("R2 zero write no effect", d, 32'hAAAA_AAAA);
    rd(8'd33, d); chk("R3 zero write no effect", d, 32'hAAAA_AAAA);

    // R5 byte strobes on bit banks
    set_vec(8'd0, 8'd32, 0);
    wr(8'd0, 32'hFFFF_FFFF, 4'b0100);
    rd(8'd0, d); chk("R5 set lane 2 only", d, 32'h00FF_0000);
    wr(8'd0, 32'hFFFF_FFFF, 4'hF);
    wr(8'd32, 32'hFFFF_FFFF, 4'b0001);
    rd(8'd0, d); chk("R5 clear lane 0 only", d, 32'hFFFF_FF00);
    set_vec(8'd0, 8'd32, 0);

    // R4 pending banks
    wr(8'd65, 32'hA5A5_0001, 4'hF);
    rd(8'd65, d); chk("R4 set-pending", d, 32'hA5A5_0001);
    rd(8'd97, d); chk("R4 clear bank reads pending", d, 32'hA5A5_0001);
    wr(8'd97, 32'h0000_0001, 4'hF);
    rd(8'd65, d); chk("R4 clear-pending", d, 32'hA5A5_0000);
    wr(8'd97, 0, 4'hF);
    rd(8'd65, d); chk("R4 zero clear no effect", d, 32'hA5A5_0000);
    set_vec(8'd64, 8'd96, 0);

    // R6 active bank ignores writes
    wr(8'd128, 32'hFFFF_FFFF, 4'hF);
    wr(8'd129, 32'hFFFF_FFFF, 4'hF);
    rd(8'd128, d); chk("R6 active write ignored", d, 0);
    rd(8'd129, d); chk("R6 active write ignored", d, 0);

    // R7 priority field sweep with single-lane strobes
    for (int i = 0; i < N; i++) begin
      logic [7:0] v;
      int sh;
      v = 8'((i * 37 + 11) & 255);
      sh = (i % 4) * 8;
      wr(8'(160 + i / 4), ~(32'hFF << sh) | (32'(v) << sh), 4'(1 << (i % 4)));
      pm[i] = v & 8'hC0;
      rd(8'(160 + i / 4), d);
      e = {pm[(i / 4) * 4 + 3], pm[(i / 4) * 4 + 2], pm[(i / 4) * 4 + 1], pm[(i / 4) * 4]};
      chk("R7 priority field", d, e);
    end

    // R8 R9 arbitration patterns
    for (int k = 0; k < 12; k++) begin
      logic [N-1:0] ev, pv;
      ev = k[0] ? {32'hFFFF_FFFF, 32'h0F0F_0F0F} : '1;
      pv = (k == 11) ? '0 : {32'h7F4A_7C15 * 32'(k + 3), 32'h9E37_79B9 * 32'(k + 1)};
      set_vec(8'd0, 8'd32, ev);
      set_vec(8'd64, 8'd96, pv);
      en_m = ev; pd_m = pv;
      run_prio = 8'hFF;
      id = arb(bp);
      #1;
      chk("R9 request present", 32'(irq_req), 32'(id >= 0));
      if (id >= 0) begin
        chk("R8 selected line", 32'(irq_id), 32'(id));
        chk("R8 selected priority", 32'(irq_prio), 32'(bp));
        run_prio = bp; #1;
        chk("R9 equal priority blocks", 32'(irq_req), 0);
        run_prio = bp + 8'd1; #1;
        chk("R9 more urgent passes", 32'(irq_req), 1);
      end
    end

    // R10 acknowledge sequence
    run_prio = 8'hFF;
    set_vec(8'd0, 8'd32, '1);
    set_vec(8'd64, 8'd96, (64'h1 << 3) | (64'h1 << 9) | (64'h1 << 40));
    en_m = '1; pd_m = (64'h1 << 3) | (64'h1 << 9) | (64'h1 << 40);
    for (int n = 0; n < 3; n++) begin
      id = arb(bp);
      #1;
      chk("R10 offered line", 32'(irq_id), 32'(id));
      pulse_ack();
      pd_m[id] = 0; ac_m[id] = 1;
      rd(8'(128 + id / 32), d); chk("R10 active set", d, ac_m[(id / 32) * 32 +: 32]);
      rd(8'(64 + id / 32), d);  chk("R10 pending cleared", d, pd_m[(id / 32) * 32 +: 32]);
    end
    chk("R10 nothing left", 32'(irq_req), 0);
    pulse_ack();
    rd(8'd128, d); chk("R10 ack without request ignored", d, ac_m[31:0]);
    rd(8'd129, d); chk("R10 ack without request ignored", d, ac_m[63:32]);
    wr(8'd129, 32'h0, 4'hF);
    wr(8'd128, 32'h0, 4'hF);
    rd(8'd128, d); chk("R6 active write ignored when set", d, ac_m[31:0]);

    // R11 completion
    foreach (ac_m[i]) if (ac_m[i]) begin
      pulse_done(i);
      ac_m[i] = 0;
      rd(8'(128 + i / 32), d); chk("R11 done clears active", d, ac_m[(i / 32) * 32 +: 32]);
    end

    // R12 hardware lines
    set_vec(8'd64, 8'd96, 0);
    @(negedge clk); irq_in[5] = 1;
    @(negedge clk);
    rd(8'd64, d); chk("R12 rising edge pends", d, 32'h20);
    chk("R12 offered", 32'(irq_id), 5);
    pulse_ack();
    rd(8'd64, d);  chk("R12 ack beats level", d, 0);
    rd(8'd128, d); chk("R12 active", d, 32'h20);
    @(negedge clk);
    rd(8'd64, d); chk("R12 high while active no repend", d, 0);
    irq_in[5] = 0;
    @(negedge clk); irq_in[5] = 1;
    @(negedge clk);
    rd(8'd64, d); chk("R12 edge while active pends", d, 32'h20);
    wr(8'd96, 32'h20, 4'hF);
    rd(8'd64, d); chk("R12 clear while active", d, 0);
    pulse_done(5);
    rd(8'd64, d); chk("R12 not yet repended", d, 0);
    @(negedge clk);
    rd(8'd64, d); chk("R12 held high repends", d, 32'h20);
    wr(8'd96, 32'h20, 4'hF);
    rd(8'd64, d); chk("R12 sw clear beats level", d, 0);
    @(negedge clk);
    rd(8'd64, d); chk("R12 level repends next cycle", d, 32'h20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule